// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat memory burst. When a burst starts, a load strobe captures the full external address. From then on only the two lowest address bits change. The upper bits stay at the captured value until the next load.

On each clock edge without a load, an active-low advance input either moves the burst to the next beat or keeps it on the current one. Holding inserts wait states between beats. The mode input chooses the beat order:

- **Linear order:** the low bits count upward modulo four.
- **Interleaved order:** each beat is the starting low bits XOR the beat index.

The block keeps a two-bit beat counter and the latched start address. It forms the output from these registers with combinational logic. After the fourth beat, further advances wrap back to the starting address.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the latched start address and the beat counter, so `burstAddr` reads all zeros after that edge.
- R2: When `loadReq` is high at a rising edge, `burstAddr` equals the sampled `extAddr` after that edge, whatever the mode.
- R3: Between loads, the bits of `burstAddr` above bit 1 keep the value that was loaded.
- R4: With `modeInterleave` low, the low two bits follow linear order. They equal the start low bits plus the beat count, modulo 4 (start 01 gives 01, 10, 11, 00).
- R5: With `modeInterleave` high, the low two bits follow interleaved order. They equal the start low bits XOR the beat count (start 01 gives 01, 00, 11, 10; start 10 gives 10, 11, 00, 01).
- R6: Without a load, `advN` high at a rising edge holds the beat count, so `burstAddr` is unchanged while the mode is unchanged.
- R7: When `loadReq` and `advN` low occur at the same edge, the load wins and the beat count restarts at zero.
- R8: After four advances, the burst wraps back to its starting address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| loadReq | input | 1 | Starts a burst by capturing `extAddr` |
| extAddr | input | ADDR_W | External starting address |
| advN | input | 1 | Low steps to the next beat, high holds the current beat |
| modeInterleave | input | 1 | High selects interleaved order, low selects linear order |
| burstAddr | output | ADDR_W | Current burst address |

## Verification
The assertions check on every cycle:
- the reset result;
- the load result, including the case where a load and an advance arrive together;
- that the upper address bits stay constant between loads;
- that a hold leaves the address unchanged;
- the single-step increment in linear order.

The interleaved sequence and the wrap back to the start after four beats depend on the start value and the beat history. Only the bench scenarios show these, by comparing full sequences against a reference model. The same applies to mode changes in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } seqCtl_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    rst,
  input  logic    loadReq,
  input  logic    advN,
  output seqCtl_t ctl
);
  // Reset outranks load, and load outranks stepping.
  always_comb begin
    ctl.clear = rst;
    ctl.load  = !rst && loadReq;
    ctl.step  = !rst && !loadReq && !advN;
  end
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] burstAddr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] startAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] lowLinear;
  logic [BEAT_W-1:0] lowInterleave;

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      startAddr <= '0;
      beatCnt   <= '0;
    end else if (ctl.load) begin
      startAddr <= extAddr;
      beatCnt   <= '0;
    end else if (ctl.step) begin
      beatCnt   <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    lowLinear     = startAddr[BEAT_W-1:0] + beatCnt;
    lowInterleave = startAddr[BEAT_W-1:0] ^ beatCnt;
  end

  assign burstAddr = {startAddr[ADDR_W-1 -: HI_W],
                      modeInterleave ? lowInterleave : lowLinear};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              advN,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] burstAddr
);
  seqCtl_t ctl;

  burst_seq_ctrl ctrl_i (
    .rst     (rst),
    .loadReq (loadReq),
    .advN    (advN),
    .ctl     (ctl)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk            (clk),
    .ctl            (ctl),
    .extAddr        (extAddr),
    .modeInterleave (modeInterleave),
    .burstAddr      (burstAddr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              loadReq,
  input logic [ADDR_W-1:0] extAddr,
  input logic              advN,
  input logic              modeInterleave,
  input logic [ADDR_W-1:0] burstAddr
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> burstAddr == '0); // R1

  AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    loadReq |=> burstAddr == $past(extAddr)); // R2

  AST_LOAD_BEATS_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (loadReq && !advN) |=> burstAddr[1:0] == $past(extAddr[1:0])); // R7

  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
    !loadReq |=> burstAddr[ADDR_W-1:2] == $past(burstAddr[ADDR_W-1:2])); // R3

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!loadReq && advN) |=>
      (modeInterleave != $past(modeInterleave)) || (burstAddr == $past(burstAddr))); // R6

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (!loadReq && !advN && !modeInterleave) |=>
      modeInterleave || (burstAddr[1:0] == 2'($past(burstAddr[1:0]) + 2'd1))); // R4
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .loadReq        (loadReq),
  .extAddr        (extAddr),
  .advN           (advN),
  .modeInterleave (modeInterleave),
  .burstAddr      (burstAddr)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              loadReq = 1'b0;
  logic [ADDR_W-1:0] extAddr = '0;
  logic              advN = 1'b1;
  logic              modeInterleave = 1'b1;
  logic [ADDR_W-1:0] burstAddr;

  int errCnt = 0;
  int chkCnt = 0;

  // Reference state
  logic [ADDR_W-1:0] mStart = '0;
  logic [1:0]        mCnt = '0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .loadReq(loadReq), .extAddr(extAddr),
    .advN(advN), .modeInterleave(modeInterleave), .burstAddr(burstAddr)
  );

  function automatic logic [ADDR_W-1:0] expAddr(logic [ADDR_W-1:0] s, logic [1:0] c, logic m);
    logic [1:0] lo;
    lo = m ? (s[1:0] ^ c) : 2'(s[1:0] + c);
    return {s[ADDR_W-1:2], lo};
  endfunction

  task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare after it.
  task automatic cyc(string tag, logic r, logic ld, logic [ADDR_W-1:0] a, logic an, logic m);
    @(negedge clk);
    rst = r; loadReq = ld; extAddr = a; advN = an; modeInterleave = m;
    @(posedge clk);
    if (r) begin mStart = '0; mCnt = '0; end
    else if (ld) begin mStart = a; mCnt = '0; end
    else if (!an) mCnt = mCnt + 2'd1;
    #1;
    check(tag, burstAddr, expAddr(mStart, mCnt, m));
  endtask

  initial begin
    #2_000_000;
    errCnt++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] hiSave;
    void'($urandom(32'h1234_5678));

    // R1 reset state
    cyc("R1 reset", 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1);
    cyc("R1 reset", 1'b1, 1'b1, 16'hABCD, 1'b0, 1'b0);
    check("R1 zero", burstAddr, '0);

    // R2/R4 linear from 01, then wrap (R8)
    cyc("R2 load", 1'b0, 1'b1, 16'h5A01, 1'b1, 1'b0);
    check("R2 value", burstAddr, 16'h5A01);
    cyc("R4 beat2", 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
    check("R4 seq", burstAddr, 16'h5A02);
    cyc("R4 beat3", 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
    check("R4 seq", burstAddr, 16'h5A03);
    cyc("R4 beat4", 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
    check("R4 seq", burstAddr, 16'h5A00);
    cyc("R8 wrap", 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0);
    check("R8 wrap", burstAddr, 16'h5A01);

    // R5 interleaved from 01
    cyc("R2 load", 1'b0, 1'b1, 16'hC301, 1'b1, 1'b1);
    cyc("R5 b2", 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 seq01", burstAddr, 16'hC300);
    cyc("R5 b3", 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 seq01", burstAddr, 16'hC303);
    cyc("R5 b4", 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 seq01", burstAddr, 16'hC302);
    cyc("R8 wrapI", 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    check("R8 wrapI", burstAddr, 16'hC301);

    // R5 interleaved from 10, with R6 holds in between
    cyc("R2 load", 1'b0, 1'b1, 16'h0012, 1'b1, 1'b1);
    cyc("R5 b2", 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 seq10", burstAddr, 16'h0013);
    cyc("R6 hold", 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1);
    check("R6 hold", burstAddr, 16'h0013);
    cyc("R6 hold", 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1);
    check("R6 hold", burstAddr, 16'h0013);
    cyc("R5 b3", 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 seq10", burstAddr, 16'h0010);
    cyc("R5 b4", 1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    check("R5 seq10", burstAddr, 16'h0011);

    // R7 load with advance in the same cycle
    cyc("R7 prio", 1'b0, 1'b1, 16'h7773, 1'b0, 1'b0);
    check("R7 prio", burstAddr, 16'h7773);

    // Random mix: R3 upper bits, R4/R5 order, R6 hold
    for (int i = 0; i < 3000; i++) begin
      logic ld, an, m, r;
      r  = ($urandom % 200) == 0;
      ld = ($urandom % 6) == 0;
      an = ($urandom % 3) == 0;
      m  = ($urandom % 8) != 0 ? modeInterleave : ~modeInterleave;
      hiSave = burstAddr;
      cyc(m ? "R5 rand" : "R4 rand", r, ld, 16'($urandom), an, m);
      if (!r && !ld) check("R3 upper", {burstAddr[ADDR_W-1:2], 2'b00}, {hiSave[ADDR_W-1:2], 2'b00});
    end

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end
endmodule